// File: doc/BRIEF.md
# Branch Trace Recorder

This block watches a stream of retired control-flow events. Each event is a taken branch, an interrupt or an exception, and carries a 32-bit source address and a 32-bit target address. A single control register chooses where the resulting 64-bit record goes. Any mix of three sinks can be enabled at once.

The first sink is an eight-deep on-chip stack that holds the most recent records. The second is a per-event message output. The third is a write port into a software-defined ring buffer in memory. When that buffer reaches its limit, it either wraps back to its start or stops and raises an interrupt.

A debug-exception input freezes the stack so that the branches leading up to the exception are kept. A control bit is also exported as a qualifier that selects single-stepping on branches. Software reads and writes the block through a flat register bus with one word per address.

Top module: `branch_trace_rec`

## Requirements
- R1: The control register sits at address 0x1D9. Bits 0, 1, 6, 7 and 8 hold what software writes. Every other bit reads zero and ignores writes. The register resets to zero, so writing 0xFFFFFFFF reads back 0x1C3.
- R2: While control bit 0 is set, each event first advances a 3-bit top-of-stack pointer, which wraps modulo 8 and resets to 0. The event then stores {target, source} into the entry that pointer now names. Entry i is read at address 0x1DA+i, and the pointer is read at 0x1E2.
- R3: A debug exception input (`dbg_exc`) clears control bit 0 at the next clock edge. An event in the same cycle as `dbg_exc` is not stored, and the stack stays unchanged afterwards.
- R4: `step_br` equals control bit 1 at all times.
- R5: While control bit 6 is set, each event produces a one-cycle `msg_valid` pulse in the cycle after the event. The pulse carries `msg_data` = {target, source}.
- R6: While control bit 7 is set, each event starts a memory write with address = base + 8 × index and data = {target, source}, and the index then advances. The base register is at 0x1E3, the limit at 0x1E4 and the write index at 0x1E5.
- R7: With control bit 8 clear, an index that would advance to the limit returns to 0 instead.
- R8: With control bit 8 set, an index that advances to the limit stays there. `buf_irq` is high while bits 7 and 8 are set and the index equals the limit. Events are then not logged until software rewrites the index.
- R9: `mem_valid` stays high with stable `mem_addr` and `mem_data` until `mem_ready` is seen.
- R10: An event to be logged while a write is stalled is dropped. It increments an 8-bit saturating counter, read at 0x1E6, and any write to that address clears the counter.
- R11: Reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | A control-flow event is present |
| ev_from | input | 32 | Source address of the event |
| ev_to | input | 32 | Target address of the event |
| dbg_exc | input | 1 | Debug exception being signalled |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| step_br | output | 1 | Single-step-on-branches qualifier |
| msg_valid | output | 1 | Trace message valid |
| msg_data | output | 64 | Trace message record |
| mem_valid | output | 1 | Buffer write request |
| mem_ready | input | 1 | Buffer write accepted |
| mem_addr | output | 32 | Buffer write byte address |
| mem_data | output | 64 | Buffer write record |
| buf_irq | output | 1 | Buffer full interrupt |

## Verification
The first event pattern is a run of ten events with the stack alone enabled. It pushes the 3-bit pointer past its wrap and shows whether old entries are overwritten in order.

A pair of events around a debug exception separates a stack that freezes in time from one that stores the exception-cycle record. Streams into a four-entry buffer are run three ways: with the wrap mode, with the halt mode, and with the write port held stalled. These show the wrap, the full stop with its interrupt, and the drop-and-count path apart.

A behavioural model is compared every cycle against all outputs and the value read back.

// File: rtl/branch_trace_rec.sv
module branch_trace_rec #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 16,
  parameter int OVF_W = 8,
  parameter logic [11:0] REG_BASE = 12'h1D9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  input  logic [31:0] ev_from,
  input  logic [31:0] ev_to,
  input  logic        dbg_exc,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        step_br,
  output logic        msg_valid,
  output logic [63:0] msg_data,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [31:0] mem_addr,
  output logic [63:0] mem_data,
  output logic        buf_irq
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [11:0] A_ENT  = REG_BASE + 12'd1;
  localparam logic [11:0] A_TOS  = A_ENT + 12'(DEPTH);
  localparam logic [11:0] A_BASE = A_TOS + 12'd1;
  localparam logic [11:0] A_LIM  = A_TOS + 12'd2;
  localparam logic [11:0] A_IDX  = A_TOS + 12'd3;
  localparam logic [11:0] A_OVF  = A_TOS + 12'd4;
  localparam logic [31:0] CTRL_MASK = 32'h0000_01C3;

  logic [31:0]      ctrl_q;
  logic [PW-1:0]    tos_q;
  logic [63:0]      lbr_q [DEPTH];
  logic [31:0]      base_q;
  logic [IDX_W-1:0] lim_q, idx_q, idx_inc, idx_nxt;
  logic [OVF_W-1:0] ovf_q;

  wire [63:0] rec    = {ev_to, ev_from};
  wire wr_ctrl       = reg_we && reg_addr == REG_BASE;
  wire wr_base       = reg_we && reg_addr == A_BASE;
  wire wr_lim        = reg_we && reg_addr == A_LIM;
  wire wr_idx        = reg_we && reg_addr == A_IDX;
  wire wr_ovf        = reg_we && reg_addr == A_OVF;
  wire full          = ctrl_q[8] && idx_q == lim_q;
  wire log_ok        = ev_valid && ctrl_q[7] && !full;
  wire busy          = mem_valid && !mem_ready;
  wire push          = ev_valid && ctrl_q[0] && !dbg_exc;

  assign idx_inc = idx_q + 1'b1;
  assign idx_nxt = (idx_inc == lim_q) ? (ctrl_q[8] ? lim_q : '0) : idx_inc;
  assign step_br = ctrl_q[1];
  assign buf_irq = ctrl_q[7] && full;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else begin
      if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_MASK;
      if (dbg_exc) ctrl_q[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos_q <= '0;
      for (int i = 0; i < DEPTH; i++) lbr_q[i] <= '0;
    end else if (push) begin
      tos_q <= tos_q + 1'b1;
      lbr_q[tos_q + 1'b1] <= rec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_data  <= '0;
    end else begin
      msg_valid <= ev_valid && ctrl_q[6];
      if (ev_valid && ctrl_q[6]) msg_data <= rec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      idx_q     <= '0;
      lim_q     <= '0;
      base_q    <= '0;
      ovf_q     <= '0;
    end else begin
      if (log_ok && busy) begin
        if (ovf_q != '1) ovf_q <= ovf_q + 1'b1;
      end else if (log_ok) begin
        mem_valid <= 1'b1;
        mem_addr  <= base_q + (32'(idx_q) << 3);
        mem_data  <= rec;
        idx_q     <= idx_nxt;
      end else if (mem_ready) begin
        mem_valid <= 1'b0;
      end
      if (wr_base) base_q <= reg_wdata;
      if (wr_lim)  lim_q  <= reg_wdata[IDX_W-1:0];
      if (wr_idx)  idx_q  <= reg_wdata[IDX_W-1:0];
      if (wr_ovf)  ovf_q  <= '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_BASE) reg_rdata = {32'd0, ctrl_q};
    if (reg_addr == A_TOS)    reg_rdata = 64'(tos_q);
    if (reg_addr == A_BASE)   reg_rdata = {32'd0, base_q};
    if (reg_addr == A_LIM)    reg_rdata = 64'(lim_q);
    if (reg_addr == A_IDX)    reg_rdata = 64'(idx_q);
    if (reg_addr == A_OVF)    reg_rdata = 64'(ovf_q);
    for (int i = 0; i < DEPTH; i++)
      if (reg_addr == A_ENT + 12'(i)) reg_rdata = lbr_q[i];
  end
endmodule

// File: rtl/brt_chk.sv
module brt_chk #(
  parameter int PW = 3,
  parameter int IDX_W = 16,
  parameter int OVF_W = 8,
  parameter logic [11:0] A_IDX = 12'h1E5,
  parameter logic [11:0] A_OVF = 12'h1E6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             dbg_exc,
  input logic             reg_we,
  input logic [11:0]      reg_addr,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [31:0]      mem_addr,
  input logic [63:0]      mem_data,
  input logic             msg_valid,
  input logic             buf_irq,
  input logic             ctrl0,
  input logic [PW-1:0]    tos_q,
  input logic [IDX_W-1:0] idx_q,
  input logic [OVF_W-1:0] ovf_q
);
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  // R5
  msg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(ev_valid));
  // R3
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |=> !ctrl0);
  // R2
  tos_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> $stable(tos_q));
  // R8
  full_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_irq && !(reg_we && reg_addr == A_IDX) |=> $stable(idx_q));
  // R10
  ovf_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_OVF) |=> ovf_q >= $past(ovf_q));
endmodule

bind branch_trace_rec brt_chk #(.PW(PW), .IDX_W(IDX_W), .OVF_W(OVF_W), .A_IDX(A_IDX), .A_OVF(A_OVF)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .dbg_exc(dbg_exc),
  .reg_we(reg_we), .reg_addr(reg_addr), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .msg_valid(msg_valid), .buf_irq(buf_irq),
  .ctrl0(ctrl_q[0]), .tos_q(tos_q), .idx_q(idx_q), .ovf_q(ovf_q));

// File: tb/sim_branch_trace_rec.sv
module sim_branch_trace_rec;
  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, dbg_exc = 0, reg_we = 0, mem_ready = 1;
  logic [31:0] ev_from = 0, ev_to = 0, reg_wdata = 0;
  logic [11:0] reg_addr = 0;
  logic [63:0] reg_rdata, msg_data, mem_data;
  logic [31:0] mem_addr;
  logic step_br, msg_valid, mem_valid, buf_irq;

  localparam logic [11:0] CTRL = 12'h1D9, ENT = 12'h1DA, TOS = 12'h1E2,
                          BASE = 12'h1E3, LIM = 12'h1E4, IDX = 12'h1E5, OVF = 12'h1E6;

  branch_trace_rec u0 (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit armed = 0, done = 0;

  logic [31:0] m_ctrl, m_base;
  logic [63:0] m_lbr [8];
  int m_tos, m_lim, m_idx, m_ovf;
  bit m_mv, m_msgv;
  logic [31:0] m_ma;
  logic [63:0] m_md, m_msgd;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mread(logic [11:0] a);
    if (a == CTRL) return {32'd0, m_ctrl};
    if (a >= ENT && a < ENT + 12'd8) return m_lbr[a - ENT];
    if (a == TOS) return 64'(m_tos);
    if (a == BASE) return {32'd0, m_base};
    if (a == LIM) return 64'(m_lim);
    if (a == IDX) return 64'(m_idx);
    if (a == OVF) return 64'(m_ovf);
    return 64'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_base = 0; m_tos = 0; m_lim = 0; m_idx = 0; m_ovf = 0;
      m_mv = 0; m_msgv = 0; m_ma = 0; m_md = 0; m_msgd = 0;
      for (int i = 0; i < 8; i++) m_lbr[i] = 0;
      armed = 1;
    end else begin
      logic [63:0] rec;
      logic [31:0] oc;
      bit full, logok, busy;
      int ni;
      rec = {ev_to, ev_from};
      oc = m_ctrl;
      m_msgv = ev_valid && oc[6];
      if (m_msgv) m_msgd = rec;
      if (ev_valid && oc[0] && !dbg_exc) begin
        m_tos = (m_tos + 1) % 8;
        m_lbr[m_tos] = rec;
      end
      full = oc[8] && m_idx == m_lim;
      logok = ev_valid && oc[7] && !full;
      busy = m_mv && !mem_ready;
      if (logok && busy) begin
        if (m_ovf < 255) m_ovf++;
      end else if (logok) begin
        m_mv = 1; m_ma = m_base + 32'(m_idx * 8); m_md = rec;
        ni = (m_idx + 1) % 65536;
        if (ni == m_lim) ni = oc[8] ? m_lim : 0;
        m_idx = ni;
      end else if (mem_ready) m_mv = 0;
      if (reg_we) begin
        if (reg_addr == CTRL) m_ctrl = reg_wdata & 32'h1C3;
        if (reg_addr == BASE) m_base = reg_wdata;
        if (reg_addr == LIM) m_lim = int'(reg_wdata[15:0]);
        if (reg_addr == IDX) m_idx = int'(reg_wdata[15:0]);
        if (reg_addr == OVF) m_ovf = 0;
      end
      if (dbg_exc) m_ctrl[0] = 1'b0;
    end
  end

  always @(negedge clk) if (armed && !done) begin
    chk("R4 step_br", 64'(step_br), 64'(m_ctrl[1]));
    chk("R5 msg_valid", 64'(msg_valid), 64'(m_msgv));
    if (m_msgv) chk("R5 msg_data", msg_data, m_msgd);
    chk("R6 R9 mem_valid", 64'(mem_valid), 64'(m_mv));
    if (m_mv) begin
      chk("R6 R7 mem_addr", 64'(mem_addr), 64'(m_ma));
      chk("R6 R9 mem_data", mem_data, m_md);
    end
    chk("R8 buf_irq", 64'(buf_irq), 64'(m_ctrl[7] && m_ctrl[8] && m_idx == m_lim));
    chk("R1 R2 R10 R11 rdata", reg_rdata, mread(reg_addr));
  end

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 0;
  endtask

  task automatic ev(logic [31:0] f, logic [31:0] t, bit dx = 0);
    ev_valid = 1; ev_from = f; ev_to = t; dbg_exc = dx;
    cyc();
    ev_valid = 0; dbg_exc = 0;
  endtask

  task automatic rd(string tag, logic [11:0] a, logic [63:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    cyc();
  endtask

  initial begin
    cyc(2);
    rst_n = 1;
    cyc();
    rd("R1 ctrl reset", CTRL, 0);
    rd("R2 tos reset", TOS, 0);
    rd("R11 unmapped", 12'h100, 0);
    wr(CTRL, 32'hFFFF_FFFF);
    rd("R1 ctrl mask", CTRL, 64'h1C3);
    @(negedge clk); chk("R4 step_br set", 64'(step_br), 1);
    cyc();
    wr(CTRL, 32'h0);
    wr(CTRL, 32'h1);
    for (int i = 0; i < 10; i++) ev(32'h100 + i, 32'h200 + i);
    rd("R2 tos wrap", TOS, 2);
    rd("R2 entry1 newest-but-one", ENT + 12'd1, {32'h208, 32'h108});
    for (int i = 0; i < 8; i++) rd("R2 entry", ENT + 12'(i), mread(ENT + 12'(i)));
    ev(32'hA0, 32'hB0);
    ev(32'hC0, 32'hD0, 1);
    ev(32'hE0, 32'hF0);
    rd("R3 frozen tos", TOS, 3);
    rd("R3 ctrl bit0 cleared", CTRL, 0);
    wr(CTRL, 32'h40);
    ev(32'h11, 32'h22);
    @(negedge clk); chk("R5 msg pulse", {63'd0, msg_valid}, 1);
    cyc();
    ev(32'h33, 32'h44);
    ev(32'h55, 32'h66);
    cyc(2);
    wr(BASE, 32'h1000);
    wr(LIM, 4);
    wr(CTRL, 32'h80);
    for (int i = 0; i < 5; i++) ev(32'h300 + i, 32'h400 + i);
    @(negedge clk); chk("R7 wrapped addr", 64'(mem_addr), 64'h1000);
    cyc(2);
    mem_ready = 0;
    wr(IDX, 0);
    for (int i = 0; i < 4; i++) ev(32'h500 + i, 32'h600 + i);
    cyc(2);
    rd("R10 overflow count", OVF, 3);
    mem_ready = 1;
    cyc(2);
    wr(OVF, 0);
    rd("R10 overflow clear", OVF, 0);
    wr(IDX, 0);
    wr(CTRL, 32'h180);
    for (int i = 0; i < 6; i++) ev(32'h700 + i, 32'h800 + i);
    @(negedge clk); chk("R8 irq raised", 64'(buf_irq), 1);
    cyc();
    rd("R8 idx held", IDX, 4);
    wr(IDX, 1);
    @(negedge clk); chk("R8 irq cleared", 64'(buf_irq), 0);
    cyc();
    ev(32'h900, 32'hA00);
    @(negedge clk); chk("R8 resumed addr", 64'(mem_addr), 64'h1008);
    cyc();
    mem_ready = 0;
    ev(32'h901, 32'hA01);
    ev(32'h902, 32'hA02);
    cyc(3);
    mem_ready = 1;
    cyc(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule